// File: doc/BRIEF.md
# Universal registered bus transceiver

This block joins two 18-bit data paths that run in opposite directions: one from port A to port B and one from port B to port A. Each direction has a storage register and three controls of its own: a pass-through (latch) enable, a capture strobe and an output enable. With pass-through set, the far port follows the near port combinationally. With pass-through clear, the far port shows the stored word. The stored word changes only when the capture strobe goes from high to low. When pass-through drops, the register keeps the last word that was present while pass-through was set.

The block is meant for a synthesizable chip, so it has no three-state pads. Each port delivers a data vector and a separate drive flag, and the pad ring turns these into bus drive. All control inputs are sampled on one system clock `clk`. A falling capture strobe is recognised at the first `clk` edge that sees it low after a sample where it was high. The A-to-B output enable is active high. The B-to-A output enable is active low.

Top module: `xcvr18`

## Requirements
- R1: An active-low asynchronous reset `rst_n` clears both stored words to zero. With pass-through clear, `b_out` and `a_out` read 0 after reset.
- R2: While `ab_le` is 1, `b_out` equals `a_in` in the same cycle, with no register on the path.
- R3: While `ab_le` is 0 and `ab_ck` stays at 1 or stays at 0, `b_out` keeps its stored word whatever `a_in` does.
- R4: While `ab_le` is 0, the stored word takes the value of `a_in` at the first `clk` rising edge where `ab_ck` is sampled 0 after a sample where it was 1. `b_out` shows the new word after that edge.
- R5: When `ab_le` goes from 1 to 0 while `ab_ck` is 0, the stored word is the `a_in` value seen at the last `clk` edge where `ab_le` was still 1. This holds even if `a_in` changes in the same cycle that `ab_le` drops.
- R6: `b_drv` is 1 exactly when `ab_oe` is 1 (active high). `a_drv` is 1 exactly when `ba_oe_n` is 0 (active low).
- R7: The data outputs always carry the live transparent-or-stored word, whether or not the port is driving. Captures still take place while the output is disabled.
- R8: The B-to-A path follows R2 to R5 using `b_in`, `ba_le` and `ba_ck`, and drives `a_out`. Activity on one direction does not change the other direction's stored word.
- R9: A rising `ab_ck` with `ab_le` at 0 does not change the stored word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all controls |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_in | input | 18 | Word arriving on port A |
| b_in | input | 18 | Word arriving on port B |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ab_le | input | 1 | A-to-B pass-through enable |
| ab_ck | input | 1 | A-to-B capture strobe, falling edge active |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A pass-through enable |
| ba_ck | input | 1 | B-to-A capture strobe, falling edge active |
| b_out | output | 18 | Word presented on port B |
| b_drv | output | 1 | Port B drive flag |
| a_out | output | 18 | Word presented on port A |
| a_drv | output | 1 | Port A drive flag |

## Verification
The bench builds the block with the default width of 18. The test words used are alternating-bit patterns, all ones, zero and mixed values. These let each bit of both lanes show a slip in transparency or capture.

At this width the bench can show the main corner cases directly:
- a word changed in the same cycle that pass-through drops, which separates R5 from a late capture;
- a word changed in the same cycle the strobe falls;
- a rising strobe that must be ignored;
- captures taken while the output is disabled.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // A falling strobe: high at the previous sample, low now.
  function automatic logic strobe_fell(input logic prev_s, input logic cur_s);
    return prev_s & ~cur_s;
  endfunction

  // The register loads while pass-through is open or on a falling strobe.
  function automatic logic load_now(input logic pass_en, input logic fell);
    return pass_en | fell;
  endfunction

  // Drive flag from the enable and its polarity.
  function automatic logic drive_flag(input logic en, input logic active_low);
    return active_low ? ~en : en;
  endfunction

endpackage

// File: rtl/xcvr_fall_det.sv
module xcvr_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic fell
);
  import xcvr_pkg::*;

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= strobe;
  end

  assign fell = strobe_fell(prev_q, strobe);

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
  parameter int W = 18,
  parameter bit OE_LOW = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         pass_en,
  input  logic         strobe,
  input  logic         oe,
  output logic [W-1:0] dout,
  output logic         drv
);
  import xcvr_pkg::*;

  logic         fell;
  logic         load;
  logic [W-1:0] store_q;
  logic         armed;

  xcvr_fall_det u_fall (
    .clk   (clk),
    .rst_n (rst_n),
    .strobe(strobe),
    .fell  (fell)
  );

  assign load = load_now(pass_en, fell);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    store_q <= '0;
    else if (load) store_q <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assign dout = pass_en ? din : store_q;

  generate
    if (OE_LOW) begin : g_oe_low
      assign drv = drive_flag(oe, 1'b1);
    end else begin : g_oe_high
      assign drv = drive_flag(oe, 1'b0);
    end
  endgenerate

  // R3 / R9: without pass-through or a falling strobe the word holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !pass_en && !fell) |=> (store_q == $past(store_q)));

  // R4: a falling strobe loads the word present at that edge
  a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && fell) |=> (store_q == $past(din)));

  // R5: after pass-through closes, the register holds the last word seen open
  a_r5_close: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $fell(pass_en)) |-> (store_q == $past(din)));

endmodule

// File: rtl/xcvr18.sv
module xcvr18 #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         ab_oe,
  input  logic         ab_le,
  input  logic         ab_ck,
  input  logic         ba_oe_n,
  input  logic         ba_le,
  input  logic         ba_ck,
  output logic [W-1:0] b_out,
  output logic         b_drv,
  output logic [W-1:0] a_out,
  output logic         a_drv
);

  xcvr_lane #(.W(W), .OE_LOW(1'b0)) u_ab (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (a_in),
    .pass_en(ab_le),
    .strobe (ab_ck),
    .oe     (ab_oe),
    .dout   (b_out),
    .drv    (b_drv)
  );

  xcvr_lane #(.W(W), .OE_LOW(1'b1)) u_ba (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (b_in),
    .pass_en(ba_le),
    .strobe (ba_ck),
    .oe     (ba_oe_n),
    .dout   (a_out),
    .drv    (a_drv)
  );

  // R6: drive flags follow the enable pins with opposite polarities
  a_r6_b_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (b_drv == ab_oe));
  a_r6_a_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (a_drv != ba_oe_n));

  // R2: transparent path seen at the top ports
  a_r2_pass: assert property (@(posedge clk) disable iff (!rst_n)
    ab_le |-> (b_out == a_in));

endmodule

// File: tb/tb_xcvr18.sv
`timescale 1ns/1ps
module tb_xcvr18;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic ab_oe = 1'b1, ab_le = 1'b0, ab_ck = 1'b0;
  logic ba_oe_n = 1'b1, ba_le = 1'b0, ba_ck = 1'b0;
  logic [W-1:0] b_out, a_out;
  logic b_drv, a_drv;

  always #2.5 clk = ~clk;

  xcvr18 #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .ab_oe(ab_oe), .ab_le(ab_le), .ab_ck(ab_ck),
    .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_ck(ba_ck),
    .b_out(b_out), .b_drv(b_drv), .a_out(a_out), .a_drv(a_drv)
  );

  typedef struct {
    bit           on_a;
    logic [W-1:0] data;
    logic         drv;
    string        tag;
  } exp_t;

  exp_t exp_q[$];
  event chk_ev;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // Monitor: pops expectations and compares with the ports
  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        exp_t e;
        logic [W-1:0] gd;
        logic gv;
        e = exp_q.pop_front();
        gd = e.on_a ? a_out : b_out;
        gv = e.on_a ? a_drv : b_drv;
        total++;
        if (gd !== e.data || gv !== e.drv) begin
          bad++;
          $display("FAIL %s: got data=%h drv=%b expected data=%h drv=%b",
                   e.tag, gd, gv, e.data, e.drv);
        end
      end
    end
  end

  task automatic expect_port(input bit on_a, input logic [W-1:0] d,
                             input logic v, input string tag);
    exp_t e;
    e.on_a = on_a; e.data = d; e.drv = v; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // One system cycle: after the rising edge the ports are settled
  task automatic settle();
    @(posedge clk); #1;
    -> chk_ev;
    #0.1;
  endtask

  task automatic at_neg();
    @(negedge clk);
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    expect_port(0, '0, 1'b1, "R1 b store cleared");
    expect_port(1, '0, 1'b0, "R1 a store cleared");
    settle();

    // R2 transparency
    at_neg(); ab_le = 1'b1; a_in = 18'h2AAAA;
    expect_port(0, 18'h2AAAA, 1'b1, "R2 pass pattern 1"); settle();
    at_neg(); a_in = 18'h15555;
    expect_port(0, 18'h15555, 1'b1, "R2 pass pattern 2"); settle();

    // R5 pass-through closes with strobe low and data changing together
    at_neg(); ab_le = 1'b0; a_in = 18'h3FFFF;
    expect_port(0, 18'h15555, 1'b1, "R5 keeps word before close"); settle();

    // R3 hold with strobe low
    at_neg(); a_in = 18'h00F0F; settle();
    expect_port(0, 18'h15555, 1'b1, "R3 hold strobe low"); settle();

    // R9 rising strobe ignored
    at_neg(); ab_ck = 1'b1; a_in = 18'h0ABCD;
    expect_port(0, 18'h15555, 1'b1, "R9 rising strobe ignored"); settle();

    // R3 hold with strobe high
    at_neg(); a_in = 18'h12345; settle();
    expect_port(0, 18'h15555, 1'b1, "R3 hold strobe high"); settle();

    // R4 capture on the falling strobe
    at_neg(); ab_ck = 1'b0; a_in = 18'h2F00F;
    expect_port(0, 18'h2F00F, 1'b1, "R4 falling capture"); settle();
    at_neg(); a_in = 18'h01111;
    expect_port(0, 18'h2F00F, 1'b1, "R4 held after capture"); settle();

    // R6 / R7 disable, capture while disabled
    at_neg(); ab_oe = 1'b0;
    expect_port(0, 18'h2F00F, 1'b0, "R6 b disabled"); settle();
    at_neg(); ab_ck = 1'b1; settle();
    at_neg(); ab_ck = 1'b0; a_in = 18'h3C3C3;
    expect_port(0, 18'h3C3C3, 1'b0, "R7 capture while disabled"); settle();
    at_neg(); ab_oe = 1'b1;
    expect_port(0, 18'h3C3C3, 1'b1, "R6 b enabled"); settle();

    // R8 B-to-A direction
    at_neg(); ba_oe_n = 1'b0;
    expect_port(1, '0, 1'b1, "R6 a enabled active low"); settle();
    at_neg(); ba_le = 1'b1; b_in = 18'h1AAAA;
    expect_port(1, 18'h1AAAA, 1'b1, "R8 a pass"); settle();
    at_neg(); ba_le = 1'b0; b_in = 18'h00001;
    expect_port(1, 18'h1AAAA, 1'b1, "R8 a keeps word on close"); settle();
    at_neg(); ba_ck = 1'b1; b_in = 18'h00777;
    expect_port(1, 18'h1AAAA, 1'b1, "R8 a rising ignored"); settle();
    at_neg(); ba_ck = 1'b0; b_in = 18'h2BCDE;
    expect_port(1, 18'h2BCDE, 1'b1, "R8 a falling capture"); settle();
    at_neg(); b_in = 18'h0;
    expect_port(1, 18'h2BCDE, 1'b1, "R8 a hold strobe low"); settle();
    expect_port(0, 18'h3C3C3, 1'b1, "R8 b unaffected by a lane");
    at_neg(); ba_oe_n = 1'b1;
    expect_port(1, 18'h2BCDE, 1'b0, "R6 a disabled"); settle();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule